// File: doc/BRIEF.md
# Duty-Cycled Supply Monitor Controller

This block is the slow-clock digital control wrapped around a brown-out comparator that watches the main I/O supply. It passes a 4-bit threshold code to the analog side. The code covers 1.9 V to 3.4 V in 100 mV steps. The block powers the comparator either all the time or in single-cycle windows. It samples the comparator's verdict at the end of each window, and it turns a detection into a reset request and/or a wake-up request, depending on two enable bits.

Two status views are kept. The live bit mirrors the most recent measurement. The sticky bit records that a detection has happened at some point and is cleared by a status-register read strobe. The duty-cycled modes cut comparator power by keeping it on for one cycle out of 32, 256 or 2048.

Comparator convention: `cmp_out` high means the supply is below the selected threshold, which is a detection.

Top module: `supmon_ctrl`

## Requirements
- R1: `cmp_thresh` always equals `cfg_thresh` in the same cycle, for all 16 codes.
- R2: In sampling codes 2, 3 and 4, `cmp_en` is high for exactly one cycle in every 32, 256 and 2048 cycles respectively. Code 1 (continuous) holds `cmp_en` high on every cycle. Codes 0, 5, 6 and 7 hold it low.
- R3: The sampling code is registered, so a new code acts on `cmp_en` from the cycle after it is presented. Any change of code restarts the period count at zero, so the first window of a sampled mode falls in the 32nd, 256th or 2048th cycle after the change.
- R4: `cmp_out` is taken only at the clock edge that ends a cycle with `cmp_en` high. A value on `cmp_out` at any other time changes no output.
- R5: `sts_live` takes the sampled `cmp_out` after each window and holds it between windows. It is forced low at any edge where a disabled code (0, 5, 6 or 7) is presented.
- R6: `sts_sticky` goes high after any window that sees `cmp_out` high. It goes low after an edge with `sr_rd` high and no detection. A detection in the same cycle as `sr_rd` leaves it high.
- R7: With `cfg_rst_en` high, `rst_req` rises after a detecting window. It stays high until a window sees no detection, `cfg_rst_en` is low at an edge, or a disabled code is presented.
- R8: With `cfg_wake_en` high, `wake_req` is high for the one cycle after each detecting window (continuously while continuous mode keeps detecting). It is low otherwise, and also when a disabled code is presented at that edge.
- R9: While `rst_n` is low and in the first cycle after reset, `cmp_en`, `sts_live`, `sts_sticky`, `rst_req` and `wake_req` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_thresh | input | 4 | Threshold code, 1.9 V + 0.1 V × code |
| cfg_mode | input | 3 | Sampling code: 0 off, 1 continuous, 2/3/4 one in 32/256/2048 |
| cfg_rst_en | input | 1 | Route detections to the reset request |
| cfg_wake_en | input | 1 | Route detections to the wake-up request |
| cmp_out | input | 1 | Comparator verdict, high = supply below threshold |
| sr_rd | input | 1 | Status register read strobe |
| cmp_en | output | 1 | Comparator power enable |
| cmp_thresh | output | 4 | Threshold code to the comparator |
| rst_req | output | 1 | System reset request |
| wake_req | output | 1 | System wake-up request |
| sts_live | output | 1 | Result of the latest measurement |
| sts_sticky | output | 1 | Detection seen since the last status read |

## Verification
Continuous mode is driven with an alternating and a pseudo-random comparator value, which shows that every cycle is a measurement. The sampled modes get a comparator input that toggles every cycle: only the window value may reach the status, so any off-window leak is exposed. The mode is changed mid-period to tell a restarted count from one that runs on. Detections are made to persist over several windows and then to vanish, which separates a held reset request from a pulsed one. Status reads are placed both on and off detecting windows to tell "set wins" from "clear wins".

// File: rtl/supmon_pkg.sv
// Package: shared sampling-mode codes and their classification.
// Assumes a 3-bit mode field; unknown codes fold into "off".
package supmon_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MD_OFF  = 3'd0;
    localparam logic [MODE_W-1:0] MD_CONT = 3'd1;
    localparam logic [MODE_W-1:0] MD_S32  = 3'd2;
    localparam logic [MODE_W-1:0] MD_S256 = 3'd3;
    localparam logic [MODE_W-1:0] MD_S2K  = 3'd4;

    typedef enum logic [1:0] {
        KIND_OFF  = 2'd0,
        KIND_CONT = 2'd1,
        KIND_SAMP = 2'd2
    } mon_kind_e;

    // Map a raw mode code onto its monitoring kind.
    function automatic mon_kind_e kind_of(input logic [MODE_W-1:0] code);
        case (code)
            MD_CONT:                 kind_of = KIND_CONT;
            MD_S32, MD_S256, MD_S2K: kind_of = KIND_SAMP;
            default:                 kind_of = KIND_OFF;
        endcase
    endfunction

endpackage

// File: rtl/supmon_window.sv
// Window generator: registers the mode code, runs the period counter and
// raises the comparator enable. Assumes the longest ratio is 2**LOG_C and
// LOG_A < LOG_B < LOG_C. A change of code restarts the count at zero.
module supmon_window
    import supmon_pkg::*;
#(
    parameter int LOG_A = 5,
    parameter int LOG_B = 8,
    parameter int LOG_C = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_in,
    output logic              win,
    output logic              off_now
);
    localparam int CNT_W = LOG_C;
    localparam int N_RATIO = 3;
    localparam int LOG_TAB [N_RATIO] = '{LOG_A, LOG_B, LOG_C};

    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_tab [N_RATIO];
    logic [CNT_W-1:0]  last_val;
    mon_kind_e         kind_q;

    // One terminal count per ratio, built from its log2 parameter.
    genvar gi;
    generate
        for (gi = 0; gi < N_RATIO; gi++) begin : g_last
            assign last_tab[gi] = CNT_W'((64'd1 << LOG_TAB[gi]) - 64'd1);
        end
    endgenerate

    // Select the terminal count for the registered mode.
    always_comb begin
        case (mode_q)
            MD_S32:  last_val = last_tab[0];
            MD_S256: last_val = last_tab[1];
            default: last_val = last_tab[2];
        endcase
    end

    // Decode the enable window and whether the incoming code is disabled.
    always_comb begin
        kind_q  = kind_of(mode_q);
        win     = (kind_q == KIND_CONT) || ((kind_q == KIND_SAMP) && (cnt_q == last_val));
        off_now = (kind_of(mode_in) == KIND_OFF);
    end

    // Register the mode and advance or restart the period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_OFF;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_in;
            if (mode_in != mode_q) begin
                cnt_q <= '0;
            end else if (kind_q == KIND_SAMP) begin
                cnt_q <= (cnt_q == last_val) ? '0 : cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

endmodule

// File: rtl/supmon_status.sv
// Status keeper: live bit follows each window's sample; sticky bit latches
// detections and clears on a read. Assumes smp is high only on the cycle
// whose closing edge ends a comparator window.
module supmon_status (
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    input  logic hit,
    input  logic off_now,
    input  logic rd,
    output logic live,
    output logic sticky
);
    // Update the live measurement result.
    always_ff @(posedge clk) begin
        if (!rst_n)       live <= 1'b0;
        else if (off_now) live <= 1'b0;
        else if (smp)     live <= hit;
    end

    // Latch detections; a read clears unless a detection lands with it.
    always_ff @(posedge clk) begin
        if (!rst_n)          sticky <= 1'b0;
        else if (smp && hit) sticky <= 1'b1;
        else if (rd)         sticky <= 1'b0;
    end

endmodule

// File: rtl/supmon_action.sv
// Action router: turns a sampled detection into a held reset request and
// a per-sample wake-up pulse, each gated by its own enable.
module supmon_action (
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    input  logic hit,
    input  logic off_now,
    input  logic rst_en,
    input  logic wake_en,
    output logic rst_req,
    output logic wake_req
);
    // Hold the reset request across consecutive detecting samples.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rst_req <= 1'b0;
        else if (off_now || !rst_en) rst_req <= 1'b0;
        else if (smp)               rst_req <= hit;
    end

    // Pulse the wake-up request after each detecting sample.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_req <= 1'b0;
        else        wake_req <= smp && hit && wake_en && !off_now;
    end

endmodule

// File: rtl/supmon_ctrl.sv
// Top: duty-cycled supply monitor controller. Passes the threshold code
// through, generates comparator windows, keeps status and routes
// detections. Runs entirely on the slow clock; inputs are synchronous.
module supmon_ctrl
    import supmon_pkg::*;
#(
    parameter int THR_W = 4,
    parameter int LOG_A = 5,
    parameter int LOG_B = 8,
    parameter int LOG_C = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] cfg_thresh,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_rst_en,
    input  logic             cfg_wake_en,
    input  logic             cmp_out,
    input  logic             sr_rd,
    output logic             cmp_en,
    output logic [THR_W-1:0] cmp_thresh,
    output logic             rst_req,
    output logic             wake_req,
    output logic             sts_live,
    output logic             sts_sticky
);
    logic win;
    logic off_now;

    // Threshold code goes straight to the analog side.
    assign cmp_thresh = cfg_thresh;
    assign cmp_en     = win;

    supmon_window #(.LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_in (cfg_mode),
        .win     (win),
        .off_now (off_now)
    );

    supmon_status u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp     (win),
        .hit     (cmp_out),
        .off_now (off_now),
        .rd      (sr_rd),
        .live    (sts_live),
        .sticky  (sts_sticky)
    );

    supmon_action u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp      (win),
        .hit      (cmp_out),
        .off_now  (off_now),
        .rst_en   (cfg_rst_en),
        .wake_en  (cfg_wake_en),
        .rst_req  (rst_req),
        .wake_req (wake_req)
    );

endmodule

// File: rtl/supmon_checker.sv
// Checker: temporal properties on the controller's ports, bound below.
module supmon_checker #(
    parameter int THR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [THR_W-1:0] cfg_thresh,
    input logic [2:0]       cfg_mode,
    input logic             cfg_rst_en,
    input logic             cfg_wake_en,
    input logic             cmp_out,
    input logic             sr_rd,
    input logic             cmp_en,
    input logic [THR_W-1:0] cmp_thresh,
    input logic             rst_req,
    input logic             wake_req,
    input logic             sts_live,
    input logic             sts_sticky
);
    logic mode_on;
    assign mode_on = (cfg_mode >= 3'd1) && (cfg_mode <= 3'd4);

    p_thresh_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_thresh == cfg_thresh);

    p_live_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && mode_on) |=> (sts_live == $past(cmp_out)));

    p_live_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && mode_on) |=> $stable(sts_live));

    p_sticky_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && cmp_out) |=> sts_sticky);

    p_sticky_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_rd && !(cmp_en && cmp_out)) |=> !sts_sticky);

    p_rst_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rst_en |=> !rst_req);

    p_wake_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && cmp_out && cfg_wake_en && mode_on) |=> wake_req);

    p_wake_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmp_en && cmp_out)) |=> !wake_req);

endmodule

bind supmon_ctrl supmon_checker #(.THR_W(THR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_thresh  (cfg_thresh),
    .cfg_mode    (cfg_mode),
    .cfg_rst_en  (cfg_rst_en),
    .cfg_wake_en (cfg_wake_en),
    .cmp_out     (cmp_out),
    .sr_rd       (sr_rd),
    .cmp_en      (cmp_en),
    .cmp_thresh  (cmp_thresh),
    .rst_req     (rst_req),
    .wake_req    (wake_req),
    .sts_live    (sts_live),
    .sts_sticky  (sts_sticky)
);

// File: tb/sim_supmon_ctrl.sv
// Bench: behavioural reference model compared at every falling edge.
module sim_supmon_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_thresh = '0;
    logic [2:0] cfg_mode = '0;
    logic       cfg_rst_en = 1'b0;
    logic       cfg_wake_en = 1'b0;
    logic       cmp_out = 1'b0;
    logic       sr_rd = 1'b0;
    logic       cmp_en, rst_req, wake_req, sts_live, sts_sticky;
    logic [3:0] cmp_thresh;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    supmon_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh), .cfg_mode(cfg_mode),
        .cfg_rst_en(cfg_rst_en), .cfg_wake_en(cfg_wake_en), .cmp_out(cmp_out),
        .sr_rd(sr_rd), .cmp_en(cmp_en), .cmp_thresh(cmp_thresh), .rst_req(rst_req),
        .wake_req(wake_req), .sts_live(sts_live), .sts_sticky(sts_sticky)
    );

    // Reference model state.
    int m_mode = 0;
    int m_cnt = 0;
    bit m_live = 0, m_sticky = 0, m_rst = 0, m_wake = 0;

    function automatic int period_of(input int md);
        case (md)
            2: return 32;
            3: return 256;
            4: return 2048;
            default: return 0;
        endcase
    endfunction

    function automatic bit model_en();
        if (m_mode == 1) return 1;
        if (period_of(m_mode) > 0 && m_cnt == period_of(m_mode) - 1) return 1;
        return 0;
    endfunction

    // Advance the model on each rising edge using the inputs it sees.
    always @(posedge clk) begin
        bit smp, hit, off;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_live = 0; m_sticky = 0; m_rst = 0; m_wake = 0;
        end else begin
            smp = model_en();
            hit = cmp_out;
            off = !(cfg_mode >= 1 && cfg_mode <= 4);
            if (smp && hit) m_sticky = 1; else if (sr_rd) m_sticky = 0;
            if (off) m_live = 0; else if (smp) m_live = hit;
            if (off || !cfg_rst_en) m_rst = 0; else if (smp) m_rst = hit;
            m_wake = smp && hit && cfg_wake_en && !off;
            if (int'(cfg_mode) != m_mode) m_cnt = 0;
            else if (period_of(m_mode) > 0) m_cnt = (m_cnt + 1) % period_of(m_mode);
            else m_cnt = 0;
            m_mode = int'(cfg_mode);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Compare every output against the model away from the rising edge.
    always @(negedge clk) begin
        if (!done) begin
            check(cmp_thresh == cfg_thresh, "R1 cmp_thresh", int'(cmp_thresh), int'(cfg_thresh));
            check(cmp_en == model_en(), "R2/R3 cmp_en", int'(cmp_en), int'(model_en()));
            check(sts_live == m_live, "R4/R5 sts_live", int'(sts_live), int'(m_live));
            check(sts_sticky == m_sticky, "R6 sts_sticky", int'(sts_sticky), int'(m_sticky));
            check(rst_req == m_rst, "R7 rst_req", int'(rst_req), int'(m_rst));
            check(wake_req == m_wake, "R8 wake_req", int'(wake_req), int'(m_wake));
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    // Measure the distance between two windows (R2 directed).
    task automatic gap_check(input int exp);
        int g = 0;
        while (!cmp_en) @(negedge clk);
        @(negedge clk);
        g = 1;
        while (!cmp_en && g < 5000) begin
            @(negedge clk);
            g++;
        end
        check(g == exp, "R2 window period", g, exp);
        @(posedge clk); #2;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lf = 16'hACE1;
        step(3);
        // R9: outputs quiet in reset
        @(negedge clk);
        check(!cmp_en && !sts_live && !sts_sticky && !rst_req && !wake_req, "R9 reset state",
              int'({cmp_en, sts_live, sts_sticky, rst_req, wake_req}), 0);
        @(posedge clk); #2;
        rst_n = 1;
        @(negedge clk);
        check(!cmp_en && !sts_live && !sts_sticky && !rst_req && !wake_req, "R9 after reset",
              int'({cmp_en, sts_live, sts_sticky, rst_req, wake_req}), 0);
        @(posedge clk); #2;

        // R1 threshold sweep, R2 continuous mode with alternating verdict
        cfg_mode = 1; cfg_rst_en = 1; cfg_wake_en = 1;
        for (int t = 0; t < 16; t++) begin
            cfg_thresh = 4'(t);
            cmp_out = t[0];
            step(1);
        end
        // R6 read with and without coinciding detection
        cmp_out = 1; sr_rd = 1; step(1);
        cmp_out = 0; step(1);
        sr_rd = 0; step(2);
        // pseudo-random verdict in continuous mode
        for (int t = 0; t < 60; t++) begin
            lf = (lf >> 1) ^ ((lf & 1) ? 16'hB400 : 0);
            cmp_out = lf[0];
            sr_rd = lf[3] & lf[5];
            step(1);
        end
        sr_rd = 0;

        // R2/R4 one in 32 with toggling verdict
        cfg_mode = 2;
        for (int t = 0; t < 100; t++) begin
            cmp_out = ~cmp_out;
            step(1);
        end
        gap_check(32);
        // R7 persistent detection over several windows, then clean
        cmp_out = 1; step(100);
        cfg_rst_en = 0; step(3);
        cfg_rst_en = 1; step(40);
        cmp_out = 0; step(40);
        // R3 mid-period code change restarts the count
        cmp_out = 1; step(10);
        cfg_mode = 3; step(300);
        gap_check(256);
        cfg_mode = 2; step(5);
        cfg_mode = 3; step(260);
        // R6 read on a detecting window
        while (!cmp_en) step(1);
        sr_rd = 1; step(1); sr_rd = 0; step(3);
        sr_rd = 1; step(1); sr_rd = 0; step(3);

        // one in 2048, toggling verdict off-window
        cfg_mode = 4; cfg_wake_en = 0;
        for (int t = 0; t < 2100; t++) begin
            cmp_out = t[1];
            step(1);
        end
        gap_check(2048);
        cfg_wake_en = 1; cmp_out = 1; step(2100);

        // R2/R5 disabled codes
        for (int c = 5; c < 8; c++) begin
            cfg_mode = 3'(c);
            cmp_out = 1;
            step(40);
        end
        cfg_mode = 0; step(20);
        cfg_mode = 1; cmp_out = 1; step(4);
        cfg_mode = 0; step(4);
        sr_rd = 1; step(1); sr_rd = 0; step(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule